// File: doc/BRIEF.md
# Accumulator Arithmetic Unit with Condition Flags

This block is the arithmetic core of a small accumulator-based microcontroller. Each cycle it takes two 8-bit operands, an incoming carry bit and a 3-bit operation code. It returns an 8-bit result, a 16-bit product and a five-bit condition-code update. The operations are add, add with carry, subtract, subtract with borrow, two's-complement negate and unsigned multiply. Adding or subtracting the two accumulators uses the same add or subtract code, with the second accumulator placed on `opb`.

The arithmetic is combinational. For every flag the block presents a next value and a write enable, so that the surrounding core can see what an instruction would do before it commits. A condition-code register sits behind this logic. It loads only the enabled flags, and only on a clock edge where the execute strobe is high. A synchronous reset clears it.

Flag bit positions in `flags_next`, `flags_wen` and `flags_q` are: bit 0 C (carry/borrow), bit 1 V (signed overflow), bit 2 Z (zero), bit 3 N (negative), bit 4 H (half carry).

Top module: `acc_alu`

## Requirements
- R1: With `op_sel` = 0 (add), `result` = (opa+opb) mod 256. C is set when the sum exceeds 255. H is the carry out of bit 3 into bit 4. V is set when two operands of equal sign give a result of the other sign. All five flags are write-enabled.
- R2: With `op_sel` = 1 (add with carry), `carry_in` is added into the sum, and flags follow the rules of R1. With any other code, `carry_in` has no effect on outputs.
- R3: With `op_sel` = 2 (subtract), `result` = (opa-opb) mod 256. C is set when the true difference is below zero (borrow). V is set when operands of opposite sign give a result whose sign differs from opa.
- R4: With `op_sel` = 3 (subtract with borrow), `carry_in` is also subtracted, and flags follow the rules of R3.
- R5: With `op_sel` = 4 (negate), `result` = (0-opa) mod 256. C is set exactly when opa is nonzero. V is set exactly when opa is 0x80.
- R6: With `op_sel` = 5 (multiply), `product` = opa*opb as 16 bits, with the high byte in bits 15:8 and the low byte in bits 7:0. `result` is the low byte. C is loaded with product bit 7. H, N, Z and V keep their values.
- R7: For codes 0 to 4, Z is set exactly when `result` is zero, and N equals bit 7 of `result`.
- R8: `flags_q` changes only on a rising clock edge with `exec_en` high. On such an edge, only the bits with `flags_wen` set take their `flags_next` value.
- R9: `rst` high on a rising edge clears `flags_q` to zero.
- R10: Codes 6 and 7 are reserved. They give zero on `result` and `product`, and they leave `flags_q` unchanged.
- R11: For codes 2, 3 and 4, H keeps its value.
- R12: For every code other than 5, `product` is `result` zero-extended to 16 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the flag register |
| exec_en | input | 1 | Execute strobe; commits enabled flags on the clock edge |
| op_sel | input | 3 | Operation code (0 add, 1 add+carry, 2 sub, 3 sub+borrow, 4 negate, 5 multiply) |
| opa | input | 8 | First operand / accumulator |
| opb | input | 8 | Second operand (memory or other accumulator) |
| carry_in | input | 1 | Incoming carry / borrow |
| result | output | 8 | Arithmetic result |
| product | output | 16 | Multiply product; zero-extended result otherwise |
| flags_next | output | 5 | Candidate flag values {H,N,Z,V,C} |
| flags_wen | output | 5 | Per-flag write enables |
| flags_q | output | 5 | Registered condition codes |

## Verification
The bench targets the signed-overflow boundaries 0x7F+1 and 0x80-1, and the sum 0x80+0x80, which sets C, V and Z at once. A swapped overflow term would miss one of these cases. It negates 0x00, 0x01 and 0x80, where a wrong borrow polarity inverts C or fails to raise V. It multiplies into products whose bit 7 is set and clear, and checks that N, Z, V and H survive. A multiply that rewrote those flags, or a subtract that cleared H, would corrupt the held flags. Idle cycles and reserved codes check that the register holds, and a mid-run reset checks the clear.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADC  = 3'd1,
    OP_SUB  = 3'd2,
    OP_SBC  = 3'd3,
    OP_NEG  = 3'd4,
    OP_MUL  = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } alu_op_e;

  localparam int FLAG_C    = 0;
  localparam int FLAG_V    = 1;
  localparam int FLAG_Z    = 2;
  localparam int FLAG_N    = 3;
  localparam int FLAG_H    = 4;
  localparam int NUM_FLAGS = 5;

endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         ci,
  output logic [W-1:0] sum,
  output logic         out_of_range,
  output logic         half,
  output logic         ovf
);
  localparam int HB = W / 2;

  logic [W-1:0] b_eff;
  logic         ci_eff;
  logic [W:0]   full;

  // subtraction as a + ~b + ~borrow; unsigned carry out inverts into a borrow
  assign b_eff  = sub ? ~b : b;
  assign ci_eff = sub ? ~ci : ci;
  assign full   = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, ci_eff};

  assign sum          = full[W-1:0];
  assign out_of_range = sub ? ~full[W] : full[W];
  // carry into bit HB recovered from the sum bit, no second adder
  assign half         = a[HB] ^ b_eff[HB] ^ full[HB];
  assign ovf          = (a[W-1] == b_eff[W-1]) && (full[W-1] != a[W-1]);

endmodule

// File: rtl/acc_alu_mul.sv
module acc_alu_mul #(
  parameter int W = 8
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] p
);
  localparam int PW = 2 * W;

  logic [PW-1:0] a_ext;
  logic [PW-1:0] b_ext;

  assign a_ext = {{W{1'b0}}, a};
  assign b_ext = {{W{1'b0}}, b};
  assign p     = a_ext * b_ext;

endmodule

// File: rtl/acc_alu_ccr.sv
module acc_alu_ccr #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [N-1:0] d,
  input  logic [N-1:0] wen,
  output logic [N-1:0] q
);
  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_bit
      always_ff @(posedge clk) begin
        if (rst) begin
          q[gi] <= 1'b0;
        end else if (load && wen[gi]) begin
          q[gi] <= d[gi];
        end
      end
    end
  endgenerate

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  exec_en,
  input  logic [2:0]            op_sel,
  input  logic [DATA_W-1:0]     opa,
  input  logic [DATA_W-1:0]     opb,
  input  logic                  carry_in,
  output logic [DATA_W-1:0]     result,
  output logic [2*DATA_W-1:0]   product,
  output logic [NUM_FLAGS-1:0]  flags_next,
  output logic [NUM_FLAGS-1:0]  flags_wen,
  output logic [NUM_FLAGS-1:0]  flags_q
);
  localparam int PW = 2 * DATA_W;

  alu_op_e            op;
  logic [DATA_W-1:0]  as_a;
  logic [DATA_W-1:0]  as_b;
  logic               as_sub;
  logic               as_ci;
  logic [DATA_W-1:0]  as_sum;
  logic               as_range;
  logic               as_half;
  logic               as_ovf;
  logic [PW-1:0]      mul_p;

  assign op     = alu_op_e'(op_sel);
  assign as_sub = (op == OP_SUB) || (op == OP_SBC) || (op == OP_NEG);
  assign as_a   = (op == OP_NEG) ? '0 : opa;
  assign as_b   = (op == OP_NEG) ? opa : opb;
  assign as_ci  = ((op == OP_ADC) || (op == OP_SBC)) ? carry_in : 1'b0;

  acc_alu_addsub #(.W(DATA_W)) addsub_i (
    .a            (as_a),
    .b            (as_b),
    .sub          (as_sub),
    .ci           (as_ci),
    .sum          (as_sum),
    .out_of_range (as_range),
    .half         (as_half),
    .ovf          (as_ovf)
  );

  acc_alu_mul #(.W(DATA_W)) mul_i (
    .a (opa),
    .b (opb),
    .p (mul_p)
  );

  always_comb begin
    result     = '0;
    flags_next = '0;
    flags_wen  = '0;
    unique case (op)
      OP_ADD, OP_ADC: begin
        result             = as_sum;
        flags_next[FLAG_H] = as_half;
        flags_wen[FLAG_H]  = 1'b1;
      end
      OP_SUB, OP_SBC, OP_NEG: begin
        result = as_sum;
      end
      OP_MUL: begin
        result = mul_p[DATA_W-1:0];
      end
      default: begin
        result = '0;
      end
    endcase

    if (op inside {OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG}) begin
      flags_next[FLAG_N] = as_sum[DATA_W-1];
      flags_next[FLAG_Z] = (as_sum == '0);
      flags_next[FLAG_V] = as_ovf;
      flags_next[FLAG_C] = as_range;
      flags_wen[FLAG_N]  = 1'b1;
      flags_wen[FLAG_Z]  = 1'b1;
      flags_wen[FLAG_V]  = 1'b1;
      flags_wen[FLAG_C]  = 1'b1;
    end else if (op == OP_MUL) begin
      flags_next[FLAG_C] = mul_p[DATA_W-1];
      flags_wen[FLAG_C]  = 1'b1;
    end
  end

  assign product = (op == OP_MUL) ? mul_p : {{DATA_W{1'b0}}, result};

  acc_alu_ccr #(.N(NUM_FLAGS)) ccr_i (
    .clk  (clk),
    .rst  (rst),
    .load (exec_en),
    .d    (flags_next),
    .wen  (flags_wen),
    .q    (flags_q)
  );

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 exec_en,
  input logic [2:0]           op_sel,
  input logic [DATA_W-1:0]    opa,
  input logic [DATA_W-1:0]    opb,
  input logic [DATA_W-1:0]    result,
  input logic [2*DATA_W-1:0]  product,
  input logic [NUM_FLAGS-1:0] flags_q
);
  localparam logic [DATA_W-1:0] SIGN_ONLY = {1'b1, {(DATA_W-1){1'b0}}};

  logic [2*DATA_W-1:0] mul_ref;
  assign mul_ref = {{DATA_W{1'b0}}, opa} * {{DATA_W{1'b0}}, opb};

  AST_RST_CLEAR: assert property (@(posedge clk) rst |=> flags_q == '0); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !exec_en |=> $stable(flags_q)); // R8
  AST_Z_FROM_RESULT: assert property (@(posedge clk) disable iff (rst)
    (exec_en && op_sel <= 3'd4) |=> flags_q[FLAG_Z] == ($past(result) == '0)); // R7
  AST_N_FROM_RESULT: assert property (@(posedge clk) disable iff (rst)
    (exec_en && op_sel <= 3'd4) |=> flags_q[FLAG_N] == $past(result[DATA_W-1])); // R7
  AST_MUL_KEEP: assert property (@(posedge clk) disable iff (rst)
    (exec_en && op_sel == 3'd5) |=> flags_q[NUM_FLAGS-1:1] == $past(flags_q[NUM_FLAGS-1:1])); // R6
  AST_MUL_PRODUCT: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 3'd5) |-> product == mul_ref); // R6
  AST_NEG_BORROW: assert property (@(posedge clk) disable iff (rst)
    (exec_en && op_sel == 3'd4) |=> flags_q[FLAG_C] == ($past(opa) != '0)); // R5
  AST_NEG_OVF: assert property (@(posedge clk) disable iff (rst)
    (exec_en && op_sel == 3'd4) |=> flags_q[FLAG_V] == ($past(opa) == SIGN_ONLY)); // R5
  AST_H_KEEP_SUB: assert property (@(posedge clk) disable iff (rst)
    (exec_en && op_sel >= 3'd2 && op_sel <= 3'd4) |=> $stable(flags_q[FLAG_H])); // R11
  AST_RSV_KEEP: assert property (@(posedge clk) disable iff (rst)
    (exec_en && op_sel >= 3'd6) |=> $stable(flags_q)); // R10

endmodule

bind acc_alu acc_alu_chk #(.DATA_W(DATA_W)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .exec_en (exec_en),
  .op_sel  (op_sel),
  .opa     (opa),
  .opb     (opb),
  .result  (result),
  .product (product),
  .flags_q (flags_q)
);

// File: tb/acc_alu_tb_top.sv
module acc_alu_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        exec_en = 1'b0;
  logic [2:0]  op_sel = 3'd0;
  logic [7:0]  opa = 8'd0;
  logic [7:0]  opb = 8'd0;
  logic        carry_in = 1'b0;
  logic [7:0]  result;
  logic [15:0] product;
  logic [4:0]  flags_next;
  logic [4:0]  flags_wen;
  logic [4:0]  flags_q;

  int checks = 0;
  int errors = 0;
  logic [4:0] m_ccr = 5'd0;

  always #2.5 clk = ~clk;

  acc_alu dut_i (
    .clk(clk), .rst(rst), .exec_en(exec_en), .op_sel(op_sel), .opa(opa), .opb(opb),
    .carry_in(carry_in), .result(result), .product(product),
    .flags_next(flags_next), .flags_wen(flags_wen), .flags_q(flags_q)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int sgn(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  // behavioural reference: flags packed {H,N,Z,V,C}
  task automatic model(input int op, input int a, input int b, input int ci,
                       output int res, output int prod, output logic [4:0] nx, output logic [4:0] we);
    int s; int ss; logic h;
    nx = 5'd0; we = 5'd0; res = 0; prod = 0; h = 1'b0;
    case (op)
      0, 1: begin
        if (op == 0) ci = 0;
        s = a + b + ci; ss = sgn(a) + sgn(b) + ci;
        h = ((a % 16) + (b % 16) + ci) > 15;
        we = 5'b11111;
      end
      2, 3: begin
        if (op == 2) ci = 0;
        s = a - b - ci; ss = sgn(a) - sgn(b) - ci; we = 5'b01111;
      end
      4: begin s = 0 - a; ss = 0 - sgn(a); we = 5'b01111; end
      5: begin
        prod = a * b; res = prod % 256; we = 5'b00001;
        nx[0] = (prod / 128) % 2;
        return;
      end
      default: return;
    endcase
    res  = (s + 512) % 256;
    prod = res;
    nx[4] = h;
    nx[3] = res > 127;
    nx[2] = res == 0;
    nx[1] = (ss > 127) || (ss < -128);
    nx[0] = (s > 255) || (s < 0);
  endtask

  task automatic run(input int op, input int a, input int b, input int ci, input bit ex, input string req);
    int res; int prod; logic [4:0] nx; logic [4:0] we;
    @(negedge clk);
    op_sel = op[2:0]; opa = a[7:0]; opb = b[7:0]; carry_in = ci[0]; exec_en = ex;
    #1;
    model(op, a, b, ci, res, prod, nx, we);
    check(req, "result", int'(result), res);
    check(req, "product", int'(product), prod);
    check(req, "flags_wen", int'(flags_wen), int'(we));
    check(req, "flags_next", int'(flags_next & flags_wen), int'(nx & we));
    @(posedge clk);
    if (rst) m_ccr = 5'd0;
    else if (ex) m_ccr = (m_ccr & ~we) | (nx & we);
    #1;
    check(req, "flags_q", int'(flags_q), int'(m_ccr));
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; exec_en = 1'b1; op_sel = 3'd0; opa = 8'hFF; opb = 8'h01;
    @(posedge clk); m_ccr = 5'd0; #1;
    check("R9", "flags_q after reset", int'(flags_q), 0);
    @(negedge clk); rst = 1'b0; exec_en = 1'b0;
  endtask

  initial begin : watchdog
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    #1; check("R9", "flags_q in reset", int'(flags_q), 0);
    @(negedge clk); rst = 1'b0;

    run(0, 8'h7F, 8'h01, 0, 1, "R1");   // V, H, N
    run(0, 8'hFF, 8'h01, 1, 1, "R1");   // C, Z, H; carry_in ignored (R2)
    run(0, 8'h80, 8'h80, 0, 1, "R1");   // C, V, Z
    run(1, 8'h0F, 8'h00, 1, 1, "R2");   // half carry from carry_in
    run(1, 8'h7F, 8'h00, 1, 1, "R2");
    run(2, 8'h00, 8'h01, 0, 1, "R3");   // borrow
    run(2, 8'h80, 8'h01, 1, 1, "R3");   // V; carry_in ignored
    run(2, 8'h7F, 8'hFF, 0, 1, "R3");   // V positive minus negative
    run(3, 8'h10, 8'h0F, 1, 1, "R4");   // zero
    run(3, 8'h00, 8'h00, 1, 1, "R4");   // borrow from carry_in
    run(4, 8'h00, 8'h00, 0, 1, "R5");   // C clear
    run(4, 8'h01, 8'h00, 0, 1, "R5");
    run(4, 8'h80, 8'h00, 0, 1, "R5");   // V set
    run(0, 8'h08, 8'h08, 0, 1, "R11");  // set H
    run(2, 8'h05, 8'h03, 0, 1, "R11");  // H kept
    run(0, 8'h80, 8'h80, 0, 1, "R6");   // set V,Z,C before multiply
    run(5, 8'h10, 8'h08, 0, 1, "R6");   // product 0x0080, C set
    run(5, 8'hFF, 8'hFF, 1, 1, "R6");   // product 0xFE01, C clear
    run(0, 8'h01, 8'h01, 0, 0, "R8");   // idle: no commit
    run(6, 8'h12, 8'h34, 1, 1, "R10");
    run(7, 8'hFF, 8'hFF, 1, 1, "R10");
    run(2, 8'h33, 8'h11, 0, 1, "R12");
    run(0, 8'hC0, 8'h40, 0, 1, "R7");
    do_reset();

    for (int i = 0; i < 600; i++) begin
      run(int'($urandom_range(0, 7)), int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
          int'($urandom_range(0, 1)), ($urandom_range(0, 3) != 0), "R7");
    end
    do_reset();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule